// File: doc/BRIEF.md
# Trimmed Centisecond Calendar Timekeeper

This block keeps wall-clock time and a calendar from a 32.768 kHz crystal tick. It arrives as a one-cycle clock enable on the system clock. The time counters hold hundredths of a second, seconds, minutes and hours. The calendar holds weekday, day of month, month, two-digit year and a running week number. The divider that turns crystal ticks into centiseconds spreads the 32768 ticks of a second over 100 slots. A signed trim value lengthens or shortens the last slot of every second, which corrects for crystal error.

A sync input serves three purposes, chosen by a mode field. It can replace the crystal with a 50 Hz reference. It can also round the running time to the nearest second, or to the nearest minute. Software loads a field through a valid/ready write channel. Software reads by taking a snapshot of every field in one cycle and then selecting bytes from that snapshot, so a read never mixes values from before and after an update. Time and date fields are BCD at the ports. Internally they are binary.

The write channel applies back-pressure. `wr_ready` is low in exactly the cycles in which the counters advance or round. A write is accepted on a cycle where `wr_valid` and `wr_ready` are both high. The sender must hold `wr_sel` and `wr_data` stable while it waits. Written values must lie inside each field's legal range.

Top module: `cal_timekeeper`

## Requirements
- R1: After reset, every time field reads 00, weekday, day, month and week read 01, year and trim read 00, and `wr_ready` is high.
- R2: With trim 0, centisecond slots last 327 or 328 crystal ticks. The choice comes from a running remainder that adds 68 per slot and takes away 100 whenever it reaches 100. A write to the centisecond field (code 0) clears the divider, so the first slot after it lasts 327 ticks and the second lasts 328. A full second lasts exactly 32768 ticks. With no tick, no write and sync off, the centisecond field holds still.
- R3: Field code 9 holds a signed two's-complement trim. The slot that ends at centisecond 99 lasts its normal length plus the trim, so 0x05 makes it 5 ticks longer and 0xFD makes it 3 ticks shorter.
- R4: Centiseconds wrap 99→00 and carry into seconds. Seconds and minutes wrap 59→00 with a carry. Hours wrap 23→00 and advance the calendar by one day. Outside a write, seconds only ever step up by one or drop to 00.
- R5: With `mode_12h` high, the hour byte (code 3) is read and written as bit 7 = PM plus BCD 01..12 in bits 6:0, where 12 AM is midnight. With `mode_12h` low, the hour byte is BCD 00..23.
- R6: A day past the last day of the month wraps to 01 and advances the month. February has 29 days when the binary year is divisible by 4, otherwise 28. April, June, September and November have 30 days; the other months have 31. The day field always lies in 1..31.
- R7: On each new day the weekday (code 4) steps 1..7 and wraps to 1. When the weekday wraps 7→1, the week number (code 8) increments, wrapping 53→01. On the 31 December to 1 January rollover the week becomes 01 and the year steps, wrapping 99→00.
- R8: Field codes are 0 centisecond, 1 second, 2 minute, 3 hour, 4 weekday, 5 day, 6 month, 7 year, 8 week, 9 trim. A write to codes 10..15 is accepted and changes nothing. `wr_ready` is low in a cycle where the counters advance or round.
- R9: A high `snap_req` at a clock edge copies all fields into the read bank. `rd_data` shows the byte chosen by `rd_sel` from that bank and does not change with later counting until the next snapshot.
- R10: In 50 Hz mode (`sync_mode` = 01), each rising edge of `sync_in` adds 2 centiseconds and crystal ticks have no effect.
- R11: In second-round mode (`sync_mode` = 10), a rising edge of `sync_in` clears the centiseconds. If they were 50 or more, the seconds also advance by one, with carry. The divider is cleared. The rounding takes precedence over a crystal step in the same cycle.
- R12: In minute-round mode (`sync_mode` = 11), a rising edge of `sync_in` clears seconds and centiseconds. If the seconds were 30 or more, the minutes also advance by one, with carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | One-cycle enable per 32.768 kHz crystal period |
| sync_in | input | 1 | Synchronous sync reference; its rising edges act |
| sync_mode | input | 2 | 00 off, 01 lock to 50 Hz, 10 round to second, 11 round to minute |
| mode_12h | input | 1 | Hour byte format: 1 = 12-hour with PM flag, 0 = 24-hour |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write channel can accept this cycle |
| wr_sel | input | 4 | Field code of the write |
| wr_data | input | 8 | Write value (BCD, hour as per mode, trim signed binary) |
| snap_req | input | 1 | Capture all fields into the read bank |
| rd_sel | input | 4 | Field code to show on rd_data |
| rd_data | output | 8 | Selected byte of the read bank |

## Verification
Two actions can fall in one cycle: a crystal step that ends a centisecond slot, and a rounding sync edge. The bench loads a centisecond value of 60, gives exactly one tick less than the slot length, and then raises the 50th-percentile sync edge together with the final tick. The expected result is the rounded value (next second, centiseconds 00), not a stepped 61. The next slot must then last 327 ticks, which shows the divider was cleared. A second overlap is provoked in the same way: a write is held on the exact tick that advances the counters. It must see `wr_ready` low, land one cycle later, and leave the stepped centisecond intact.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NUM_FIELDS = 10;
  localparam int VAL_W      = 7;
  localparam int TRIM_BITS  = 8;

  typedef enum logic [3:0] {
    F_CSEC = 4'd0, F_SEC = 4'd1, F_MIN = 4'd2, F_HOUR = 4'd3, F_WDAY = 4'd4,
    F_DAY = 4'd5, F_MON = 4'd6, F_YEAR = 4'd7, F_WEEK = 4'd8, F_TRIM = 4'd9
  } field_e;

  typedef enum logic [1:0] {
    SYNC_OFF = 2'd0, SYNC_50HZ = 2'd1, SYNC_SEC = 2'd2, SYNC_MIN = 2'd3
  } sync_e;

  function automatic logic [VAL_W-1:0] bcd2bin(input logic [7:0] b);
    return VAL_W'(b[7:4]) * VAL_W'(10) + VAL_W'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [VAL_W-1:0] v);
    return 8'({1'b0, v / VAL_W'(10)} << 4) | 8'(v % VAL_W'(10));
  endfunction

  function automatic logic [VAL_W-1:0] month_len(input logic [VAL_W-1:0] m,
                                                 input logic leap);
    case (m)
      VAL_W'(2):                                    return leap ? VAL_W'(29) : VAL_W'(28);
      VAL_W'(4), VAL_W'(6), VAL_W'(9), VAL_W'(11):  return VAL_W'(30);
      default:                                      return VAL_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SLOTS         = 100,
  parameter int TRIM_W        = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_i,
  input  logic                     run_i,
  input  logic                     clear_i,
  input  logic                     last_slot_i,
  input  logic signed [TRIM_W-1:0] trim_i,
  output logic                     step_o
);
  localparam int BASE = TICKS_PER_SEC / SLOTS;
  localparam int REM  = TICKS_PER_SEC % SLOTS;
  localparam int CW   = $clog2(BASE + (2 ** (TRIM_W - 1)) + 2);
  localparam int AW   = $clog2(2 * SLOTS);

  logic [CW-1:0] cnt_q, len, trim_adj;
  logic [AW-1:0] acc_q, acc_sum;
  logic          extra;

  always_comb begin
    acc_sum  = acc_q + AW'(REM);
    extra    = (acc_sum >= AW'(SLOTS));
    trim_adj = last_slot_i ? CW'(trim_i) : '0;
    len      = CW'(BASE) + CW'(extra) + trim_adj;
    step_o   = run_i && tick_i && (cnt_q >= len - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (run_i && tick_i) begin
      if (step_o) begin
        cnt_q <= '0;
        if (last_slot_i)  acc_q <= '0;
        else if (extra)   acc_q <= acc_sum - AW'(SLOTS);
        else              acc_q <= acc_sum;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/cal_tod.sv
module cal_tod import cal_pkg::*; #(
  parameter int SLOTS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       inc_i,
  input  logic             round_sec_i,
  input  logic             round_min_i,
  input  logic [3:0]       ld_i,
  input  logic [VAL_W-1:0] ld_val_i,
  output logic [VAL_W-1:0] cs_o,
  output logic [VAL_W-1:0] sec_o,
  output logic [VAL_W-1:0] min_o,
  output logic [VAL_W-1:0] hr_o,
  output logic             day_carry_o
);
  localparam int SEC_MAX  = 59;
  localparam int MIN_MAX  = 59;
  localparam int HR_MAX   = 23;
  localparam int HALF_SEC = SLOTS / 2;
  localparam int HALF_MIN = (SEC_MAX + 1) / 2;

  logic [VAL_W-1:0] cs_q, sec_q, min_q, hr_q;
  logic [VAL_W-1:0] cs_n, sec_n, min_n, hr_n;
  logic [VAL_W:0]   cs_sum;
  logic             c_sec, c_min, c_hr;

  always_comb begin
    cs_n   = cs_q;
    sec_n  = sec_q;
    min_n  = min_q;
    hr_n   = hr_q;
    c_sec  = 1'b0;
    c_min  = 1'b0;
    c_hr   = 1'b0;
    cs_sum = {1'b0, cs_q} + (VAL_W + 1)'(inc_i);
    if (round_sec_i) begin
      cs_n  = '0;
      c_sec = (cs_q >= VAL_W'(HALF_SEC));
    end else if (round_min_i) begin
      cs_n  = '0;
      sec_n = '0;
      c_min = (sec_q >= VAL_W'(HALF_MIN));
    end else if (cs_sum >= (VAL_W + 1)'(SLOTS)) begin
      c_sec = 1'b1;
      cs_n  = VAL_W'(cs_sum - (VAL_W + 1)'(SLOTS));
    end else begin
      cs_n  = VAL_W'(cs_sum);
    end
    if (c_sec) begin
      if (sec_q >= VAL_W'(SEC_MAX)) begin
        sec_n = '0;
        c_min = 1'b1;
      end else begin
        sec_n = sec_q + VAL_W'(1);
      end
    end
    if (c_min) begin
      if (min_q >= VAL_W'(MIN_MAX)) begin
        min_n = '0;
        c_hr  = 1'b1;
      end else begin
        min_n = min_q + VAL_W'(1);
      end
    end
    if (c_hr) begin
      hr_n = (hr_q >= VAL_W'(HR_MAX)) ? '0 : hr_q + VAL_W'(1);
    end
  end

  assign day_carry_o = c_hr && (hr_q >= VAL_W'(HR_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= '0;
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
    end else begin
      cs_q  <= ld_i[0] ? ld_val_i : cs_n;
      sec_q <= ld_i[1] ? ld_val_i : sec_n;
      min_q <= ld_i[2] ? ld_val_i : min_n;
      hr_q  <= ld_i[3] ? ld_val_i : hr_n;
    end
  end

  assign cs_o  = cs_q;
  assign sec_o = sec_q;
  assign min_o = min_q;
  assign hr_o  = hr_q;
endmodule

// File: rtl/cal_date.sv
module cal_date import cal_pkg::*; #(
  parameter int YEARS = 100,
  parameter int WEEKS = 53,
  parameter int WDAYS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             day_i,
  input  logic [4:0]       ld_i,
  input  logic [VAL_W-1:0] ld_val_i,
  output logic [VAL_W-1:0] wday_o,
  output logic [VAL_W-1:0] day_o,
  output logic [VAL_W-1:0] mon_o,
  output logic [VAL_W-1:0] year_o,
  output logic [VAL_W-1:0] week_o
);
  localparam int MONTHS = 12;

  logic [VAL_W-1:0] wday_q, day_q, mon_q, year_q, week_q;
  logic [VAL_W-1:0] wday_n, day_n, mon_n, year_n, week_n;
  logic             leap, month_end, year_end, week_wrap;

  always_comb begin
    leap      = (year_q[1:0] == 2'b00);
    month_end = (day_q >= month_len(mon_q, leap));
    year_end  = month_end && (mon_q >= VAL_W'(MONTHS));
    week_wrap = (wday_q >= VAL_W'(WDAYS));
    wday_n = wday_q;
    day_n  = day_q;
    mon_n  = mon_q;
    year_n = year_q;
    week_n = week_q;
    if (day_i) begin
      wday_n = week_wrap ? VAL_W'(1) : wday_q + VAL_W'(1);
      day_n  = month_end ? VAL_W'(1) : day_q + VAL_W'(1);
      if (month_end)
        mon_n = (mon_q >= VAL_W'(MONTHS)) ? VAL_W'(1) : mon_q + VAL_W'(1);
      if (year_end)
        year_n = (year_q >= VAL_W'(YEARS - 1)) ? '0 : year_q + VAL_W'(1);
      if (year_end)
        week_n = VAL_W'(1);
      else if (week_wrap)
        week_n = (week_q >= VAL_W'(WEEKS)) ? VAL_W'(1) : week_q + VAL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wday_q <= VAL_W'(1);
      day_q  <= VAL_W'(1);
      mon_q  <= VAL_W'(1);
      year_q <= '0;
      week_q <= VAL_W'(1);
    end else begin
      wday_q <= ld_i[0] ? ld_val_i : wday_n;
      day_q  <= ld_i[1] ? ld_val_i : day_n;
      mon_q  <= ld_i[2] ? ld_val_i : mon_n;
      year_q <= ld_i[3] ? ld_val_i : year_n;
      week_q <= ld_i[4] ? ld_val_i : week_n;
    end
  end

  assign wday_o = wday_q;
  assign day_o  = day_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;
  assign week_o = week_q;
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper import cal_pkg::*; #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SLOTS         = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_tick,
  input  logic       sync_in,
  input  logic [1:0] sync_mode,
  input  logic       mode_12h,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       snap_req,
  input  logic [3:0] rd_sel,
  output logic [7:0] rd_data
);
  localparam int NF      = NUM_FIELDS;
  localparam int HALFDAY = 12;

  logic                       sync_q, sync_edge, lock50, rnd_sec, rnd_min;
  logic                       x_step, advance, wr_fire, div_clr, day_carry;
  logic [1:0]                 inc;
  logic [NF-1:0]              ld_vec;
  logic [VAL_W-1:0]           ld_val, wr_h12, rd_h12;
  logic [VAL_W-1:0]           cs_q, sec_q, min_q, hr_q;
  logic [VAL_W-1:0]           wday_q, day_q, mon_q, year_q, week_q;
  logic signed [TRIM_BITS-1:0] trim_q;
  logic                       rd_pm;
  logic [7:0]                 live [NF];
  logic [7:0]                 snap [NF];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  always_comb begin
    sync_edge = sync_in && !sync_q;
    lock50    = (sync_e'(sync_mode) == SYNC_50HZ);
    rnd_sec   = sync_edge && (sync_e'(sync_mode) == SYNC_SEC);
    rnd_min   = sync_edge && (sync_e'(sync_mode) == SYNC_MIN);
    if (lock50)      inc = sync_edge ? 2'd2 : 2'd0;
    else if (x_step) inc = 2'd1;
    else             inc = 2'd0;
    advance  = x_step || (sync_edge && (sync_e'(sync_mode) != SYNC_OFF));
    wr_ready = !advance;
    wr_fire  = wr_valid && wr_ready;
    ld_vec   = wr_fire ? (NF'(1) << wr_sel) : '0;
    div_clr  = rnd_sec || rnd_min || ld_vec[F_CSEC];
  end

  always_comb begin
    wr_h12 = bcd2bin({1'b0, wr_data[6:0]});
    if (wr_sel == 4'(F_HOUR) && mode_12h) begin
      if (wr_h12 == VAL_W'(HALFDAY))
        ld_val = wr_data[7] ? VAL_W'(HALFDAY) : '0;
      else
        ld_val = wr_data[7] ? wr_h12 + VAL_W'(HALFDAY) : wr_h12;
    end else begin
      ld_val = bcd2bin(wr_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               trim_q <= '0;
    else if (ld_vec[F_TRIM])  trim_q <= $signed(wr_data);
  end

  cal_divider #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .SLOTS        (SLOTS),
    .TRIM_W       (TRIM_BITS)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (xtal_tick),
    .run_i      (!lock50),
    .clear_i    (div_clr),
    .last_slot_i(cs_q == VAL_W'(SLOTS - 1)),
    .trim_i     (trim_q),
    .step_o     (x_step)
  );

  cal_tod #(.SLOTS(SLOTS)) u_tod (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (inc),
    .round_sec_i(rnd_sec),
    .round_min_i(rnd_min),
    .ld_i       (ld_vec[3:0]),
    .ld_val_i   (ld_val),
    .cs_o       (cs_q),
    .sec_o      (sec_q),
    .min_o      (min_q),
    .hr_o       (hr_q),
    .day_carry_o(day_carry)
  );

  cal_date u_date (
    .clk     (clk),
    .rst_n   (rst_n),
    .day_i   (day_carry),
    .ld_i    (ld_vec[8:4]),
    .ld_val_i(ld_val),
    .wday_o  (wday_q),
    .day_o   (day_q),
    .mon_o   (mon_q),
    .year_o  (year_q),
    .week_o  (week_q)
  );

  always_comb begin
    rd_pm = (hr_q >= VAL_W'(HALFDAY));
    if (hr_q == '0 || hr_q == VAL_W'(HALFDAY)) rd_h12 = VAL_W'(HALFDAY);
    else if (rd_pm)                            rd_h12 = hr_q - VAL_W'(HALFDAY);
    else                                       rd_h12 = hr_q;
    live[F_CSEC] = bin2bcd(cs_q);
    live[F_SEC]  = bin2bcd(sec_q);
    live[F_MIN]  = bin2bcd(min_q);
    live[F_HOUR] = mode_12h ? {rd_pm, bin2bcd(rd_h12)[6:0]} : bin2bcd(hr_q);
    live[F_WDAY] = bin2bcd(wday_q);
    live[F_DAY]  = bin2bcd(day_q);
    live[F_MON]  = bin2bcd(mon_q);
    live[F_YEAR] = bin2bcd(year_q);
    live[F_WEEK] = bin2bcd(week_q);
    live[F_TRIM] = trim_q;
  end

  for (genvar g = 0; g < NF; g++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rst_n)        snap[g] <= '0;
      else if (snap_req) snap[g] <= live[g];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NF; i++)
      if (rd_sel == 4'(i)) rd_data = snap[i];
  end
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       xtal_tick,
  input logic       sync_in,
  input logic [1:0] sync_mode,
  input logic       mode_12h,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       snap_req,
  input logic [6:0] cs,
  input logic [6:0] sec,
  input logic [6:0] day,
  input logic [7:0] snap_hour
);
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!xtal_tick && !wr_valid) && $past(sync_mode) == 2'b00) |-> $stable(cs)); // R2

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec != $past(sec) && !$past(wr_valid && wr_ready))
      |-> (sec == $past(sec) + 7'd1 || sec == 7'd0)); // R4

  AST_DAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (day >= 7'd1 && day <= 7'd31)); // R6

  AST_STALL_ON_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != $past(cs) && !$past(wr_valid && wr_ready)) |-> !$past(wr_ready)); // R8

  AST_HOUR_12H: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snap_req && mode_12h)
      |-> (snap_hour[6:0] != 7'h00 && snap_hour[6:0] <= 7'h12)); // R5

  AST_SYNC_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(sync_in)); // R10
endmodule

bind cal_timekeeper cal_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .xtal_tick(xtal_tick),
  .sync_in  (sync_in),
  .sync_mode(sync_mode),
  .mode_12h (mode_12h),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .snap_req (snap_req),
  .cs       (cs_q),
  .sec      (sec_q),
  .day      (day_q),
  .snap_hour(snap[3])
);

// File: tb/test_cal_timekeeper.sv
module test_cal_timekeeper;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] S_CS = 4'd0, S_SEC = 4'd1, S_MIN = 4'd2, S_HR = 4'd3,
    S_WD = 4'd4, S_DAY = 4'd5, S_MON = 4'd6, S_YR = 4'd7, S_WK = 4'd8, S_TRIM = 4'd9;
  // {year, month, day, weekday, week} before -> after one midnight
  localparam logic [79:0] VEC [8] = '{
    80'h24_02_28_03_09_24_02_29_04_09,
    80'h23_02_28_02_09_23_03_01_03_09,
    80'h24_02_29_04_09_24_03_01_05_09,
    80'h23_04_30_07_17_23_05_01_01_18,
    80'h23_12_31_07_52_24_01_01_01_01,
    80'h99_12_31_05_52_00_01_01_06_01,
    80'h23_01_31_01_05_23_02_01_02_05,
    80'h23_06_15_07_53_23_06_16_01_01
  };

  logic clk = 1'b0, rst_n = 1'b0, xtal_tick = 1'b0, sync_in = 1'b0;
  logic [1:0] sync_mode = 2'b00;
  logic mode_12h = 1'b0, wr_valid = 1'b0, snap_req = 1'b0, wr_ready;
  logic [3:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [79:0] vec;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cal_timekeeper i_cal_timekeeper (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .sync_in(sync_in),
    .sync_mode(sync_mode), .mode_12h(mode_12h), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
    .snap_req(snap_req), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk); xtal_tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); xtal_tick = 1'b0;
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_sel = s; wr_data = d; #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic take_snap();
    @(negedge clk); snap_req = 1'b1;
    @(posedge clk); @(negedge clk); snap_req = 1'b0;
  endtask

  task automatic see(input string req, input string what,
                     input logic [3:0] s, input logic [7:0] exp);
    rd_sel = s; #1;
    chk(req, what, rd_data, exp);
  endtask

  task automatic pulse();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    #1 chk("R1", "wr_ready", {7'd0, wr_ready}, 8'h01);
    take_snap();
    see("R1", "cs", S_CS, 8'h00);   see("R1", "sec", S_SEC, 8'h00);
    see("R1", "min", S_MIN, 8'h00); see("R1", "hour", S_HR, 8'h00);
    see("R1", "wday", S_WD, 8'h01); see("R1", "day", S_DAY, 8'h01);
    see("R1", "mon", S_MON, 8'h01); see("R1", "year", S_YR, 8'h00);
    see("R1", "week", S_WK, 8'h01); see("R1", "trim", S_TRIM, 8'h00);

    // R4 R6 R7 midnight rollover table
    for (int i = 0; i < 8; i++) begin
      vec = VEC[i];
      wr(S_YR, vec[79:72]); wr(S_MON, vec[71:64]); wr(S_DAY, vec[63:56]);
      wr(S_WD, vec[55:48]); wr(S_WK, vec[47:40]);
      wr(S_HR, 8'h23); wr(S_MIN, 8'h59); wr(S_SEC, 8'h59); wr(S_CS, 8'h99);
      ticks(327);
      take_snap();
      see("R4", "hour", S_HR, 8'h00);  see("R4", "min", S_MIN, 8'h00);
      see("R4", "cs", S_CS, 8'h00);
      see("R7", "year", S_YR, vec[39:32]); see("R6", "mon", S_MON, vec[31:24]);
      see("R6", "day", S_DAY, vec[23:16]); see("R7", "wday", S_WD, vec[15:8]);
      see("R7", "week", S_WK, vec[7:0]);
    end

    // R2 slot lengths 327 then 328
    wr(S_CS, 8'h00);
    ticks(326); take_snap(); see("R2", "slot0 early", S_CS, 8'h00);
    ticks(1);   take_snap(); see("R2", "slot0 end", S_CS, 8'h01);
    ticks(327); take_snap(); see("R2", "slot1 early", S_CS, 8'h01);
    ticks(1);   take_snap(); see("R2", "slot1 end", S_CS, 8'h02);

    // R2 one full second is 32768 ticks
    wr(S_SEC, 8'h10); wr(S_CS, 8'h00);
    ticks(32767); take_snap();
    see("R2", "sec before", S_SEC, 8'h10); see("R2", "cs before", S_CS, 8'h99);
    ticks(1); take_snap();
    see("R2", "sec after", S_SEC, 8'h11); see("R2", "cs after", S_CS, 8'h00);

    // R3 positive and negative trim
    wr(S_TRIM, 8'h05); wr(S_SEC, 8'h20); wr(S_CS, 8'h99);
    ticks(331); take_snap(); see("R3", "trim+5 early", S_SEC, 8'h20);
    ticks(1);   take_snap(); see("R3", "trim+5 end", S_SEC, 8'h21);
    wr(S_TRIM, 8'hFD); wr(S_CS, 8'h99);
    ticks(323); take_snap(); see("R3", "trim-3 early", S_SEC, 8'h21);
    ticks(1);   take_snap(); see("R3", "trim-3 end", S_SEC, 8'h22);
    see("R3", "trim readback", S_TRIM, 8'hFD);
    wr(S_TRIM, 8'h00);

    // R9 snapshot stays put while time runs
    wr(S_CS, 8'h40); take_snap(); ticks(327);
    see("R9", "held snapshot", S_CS, 8'h40);
    take_snap(); see("R9", "new snapshot", S_CS, 8'h41);

    // R8 write collides with an advance step
    wr(S_SEC, 8'h05); wr(S_CS, 8'h00);
    ticks(326);
    xtal_tick = 1'b1; wr_valid = 1'b1; wr_sel = S_SEC; wr_data = 8'h42;
    #1 chk("R8", "ready on step", {7'd0, wr_ready}, 8'h00);
    @(negedge clk); xtal_tick = 1'b0;
    #1 chk("R8", "ready after", {7'd0, wr_ready}, 8'h01);
    @(posedge clk); @(negedge clk); wr_valid = 1'b0;
    take_snap();
    see("R8", "sec landed", S_SEC, 8'h42); see("R8", "cs kept", S_CS, 8'h01);
    wr(4'hC, 8'h55); take_snap();
    see("R8", "bad code sec", S_SEC, 8'h42); see("R8", "bad code trim", S_TRIM, 8'h00);

    // R5 hour formats
    mode_12h = 1'b0; wr(S_HR, 8'h13);
    mode_12h = 1'b1; take_snap(); see("R5", "13h as 12h", S_HR, 8'h81);
    wr(S_HR, 8'h12); mode_12h = 1'b0; take_snap(); see("R5", "12AM", S_HR, 8'h00);
    mode_12h = 1'b1; take_snap(); see("R5", "midnight 12h", S_HR, 8'h12);
    wr(S_HR, 8'h92); mode_12h = 1'b0; take_snap(); see("R5", "12PM", S_HR, 8'h12);

    // R10 locked to 50 Hz
    sync_mode = 2'b01; wr(S_CS, 8'h00);
    pulse(); pulse(); pulse();
    take_snap(); see("R10", "three edges", S_CS, 8'h06);
    ticks(400); take_snap(); see("R10", "crystal ignored", S_CS, 8'h06);

    // R11 round to second, including the collision with a step
    sync_mode = 2'b10; wr(S_SEC, 8'h20); wr(S_CS, 8'h49);
    pulse(); take_snap();
    see("R11", "down sec", S_SEC, 8'h20); see("R11", "down cs", S_CS, 8'h00);
    wr(S_CS, 8'h50); pulse(); take_snap();
    see("R11", "up sec", S_SEC, 8'h21); see("R11", "up cs", S_CS, 8'h00);
    wr(S_CS, 8'h60); ticks(326);
    xtal_tick = 1'b1; sync_in = 1'b1;
    @(negedge clk); xtal_tick = 1'b0; sync_in = 1'b0;
    take_snap();
    see("R11", "collide sec", S_SEC, 8'h22); see("R11", "collide cs", S_CS, 8'h00);
    ticks(326); take_snap(); see("R11", "divider cleared", S_CS, 8'h00);
    ticks(1);   take_snap(); see("R11", "first slot", S_CS, 8'h01);

    // R12 round to minute
    sync_mode = 2'b11; wr(S_MIN, 8'h15); wr(S_SEC, 8'h30); wr(S_CS, 8'h10);
    pulse(); take_snap();
    see("R12", "up min", S_MIN, 8'h16); see("R12", "up sec", S_SEC, 8'h00);
    see("R12", "up cs", S_CS, 8'h00);
    wr(S_SEC, 8'h29); pulse(); take_snap();
    see("R12", "down min", S_MIN, 8'h16); see("R12", "down sec", S_SEC, 8'h00);
    sync_mode = 2'b00;

    report();
  end
endmodule